// File: doc/BRIEF.md
# 1-Wire Search ROM Accelerator

This datapath sits between a host's byte interface and a 1-Wire bit-slot engine. In normal mode, a byte exchange becomes eight time slots. Each slot writes one bit of the transmit byte, least significant bit first, and the bits sampled on the bus are assembled into the receive byte.

When the search-accelerator mode is latched at the start of an exchange, the exchange becomes four search triplets. Each triplet has three slots:

- a read of the ROM bit;
- a read of its complement;
- a write of the chosen direction bit.

The block records a discrepancy flag for each triplet and packs all four results into the receive byte. After the search command byte has gone out in normal mode, sixteen accelerated exchanges walk a complete 64-bit ROM code. Each exchange resolves four bits, lowest nibble first.

The host steers the search through the odd bits of the transmit byte. A transmit byte of 0x00 takes the 0 branch at every discrepancy. Branch bookkeeping, bus reset and CRC checking belong to the host.

Top module: `ow_search_accel`

## Requirements
- R1: After reset, `busy`, `slot_req` and `rx_full` are low and `rx_byte` is 0x00.
- R2: An exchange starts only on `tx_valid` while `busy` is low. `accel_en` and `tx_byte` are sampled at that start. A `tx_valid` pulse or a change of `accel_en` during an exchange has no effect on its slots or its result.
- R3: In normal mode, an exchange issues exactly eight slots. Slot k drives `slot_bit` = `tx_byte[k]`, and `rx_byte[k]` receives the bit read in slot k.
- R4: In accelerator mode, an exchange issues exactly twelve slots as four triplets. Each triplet is a read slot (`slot_bit`=1), a complement read slot (`slot_bit`=1), and a write slot that drives the direction bit.
- R5: When the two reads of a triplet differ, the direction is the first read and the discrepancy flag is 0.
- R6: When both reads are 0, the discrepancy flag is 1. The direction for triplet t is `tx_byte[2t+1]`, so 0x00 takes the 0 branch everywhere.
- R7: When both reads are 1 (no device responding), the discrepancy flag is 1 and the direction bit written and reported is 1.
- R8: In accelerator mode, `rx_byte[2t]` holds the discrepancy flag and `rx_byte[2t+1]` holds the direction bit of triplet t, with t = 0 the earliest.
- R9: `rx_byte` changes only when an exchange completes. On the clock edge that accepts the last `slot_done`, `rx_byte` is loaded and `rx_full` is set. `rx_full` then stays high until `rx_take`, and `busy` is low from the following cycle.
- R10: Sixteen accelerated exchanges against a single responding device return its 64-bit ROM code. Exchange i yields ROM bits 4i to 4i+3 in its odd bit positions, and all discrepancy flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accel_en | input | 1 | Search-accelerator mode, sampled at exchange start |
| tx_valid | input | 1 | Start an exchange with `tx_byte` (accepted while idle) |
| tx_byte | input | 8 | Transmit byte / branch directions |
| rx_take | input | 1 | Host consumed the receive byte; clears `rx_full` |
| slot_done | input | 1 | Bit engine finished the current slot (one-cycle pulse) |
| slot_rbit | input | 1 | Bus level sampled in the finished slot, valid with `slot_done` |
| busy | output | 1 | Exchange in progress |
| slot_req | output | 1 | Request for a time slot, held until `slot_done` |
| slot_bit | output | 1 | Bit to write in the requested slot (1 for a read slot) |
| rx_byte | output | 8 | Receive byte |
| rx_full | output | 1 | Receive byte holds a completed result |

## Verification
The bound checker checks four things on every cycle:

- that an exchange only begins after a start request;
- that the receive byte never moves mid-exchange;
- that completion always leaves the receive flag set;
- that the direction registered after a complement read follows the differing-bit and no-responder rules.

The rule for both reads being 0 depends on the latched transmit byte, so its checks are left to the bench. The same holds for the bit packing, the slot counts and patterns per mode, and immunity to mid-exchange requests. The bench's scripted bus responses are also the only way to show the full sixteen-exchange reconstruction of a ROM code, nibble order included.

// File: rtl/ow_search_accel.sv
module ow_search_accel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accel_en,
  input  logic       tx_valid,
  input  logic [7:0] tx_byte,
  input  logic       rx_take,
  input  logic       slot_done,
  input  logic       slot_rbit,
  output logic       busy,
  output logic       slot_req,
  output logic       slot_bit,
  output logic [7:0] rx_byte,
  output logic       rx_full
);
  localparam int NTRIP = 4;
  localparam int NBITS = 8;

  logic       acc;
  logic [7:0] txr, rxr, rx_nxt;
  logic [2:0] idx;
  logic [1:0] ph;
  logic       a_r, dir_r;

  wire last    = acc ? (idx == 3'(NTRIP - 1) && ph == 2'd2) : (idx == 3'(NBITS - 1));
  wire odd_tx  = txr[{idx[1:0], 1'b1}];
  wire nxt_dir = (a_r != slot_rbit) ? a_r : (a_r ? 1'b1 : odd_tx);

  assign slot_req = busy;
  assign slot_bit = acc ? ((ph == 2'd2) ? dir_r : 1'b1) : txr[idx];

  always_comb begin
    rx_nxt = rxr;
    if (acc) begin
      if (ph == 2'd1) rx_nxt[{idx[1:0], 1'b0}] = (a_r == slot_rbit);
      if (ph == 2'd2) rx_nxt[{idx[1:0], 1'b1}] = dir_r;
    end else begin
      rx_nxt[idx] = slot_rbit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      acc     <= 1'b0;
      txr     <= '0;
      rxr     <= '0;
      idx     <= '0;
      ph      <= '0;
      a_r     <= 1'b0;
      dir_r   <= 1'b0;
      rx_byte <= '0;
      rx_full <= 1'b0;
    end else begin
      if (rx_take) rx_full <= 1'b0;
      if (!busy) begin
        if (tx_valid) begin
          busy <= 1'b1;
          acc  <= accel_en;
          txr  <= tx_byte;
          rxr  <= '0;
          idx  <= '0;
          ph   <= '0;
        end
      end else if (slot_done) begin
        rxr <= rx_nxt;
        if (acc) begin
          case (ph)
            2'd0: a_r <= slot_rbit;
            2'd1: dir_r <= nxt_dir;
            default: ;
          endcase
          if (ph == 2'd2) begin
            ph  <= '0;
            idx <= idx + 3'd1;
          end else begin
            ph <= ph + 2'd1;
          end
        end else begin
          idx <= idx + 3'd1;
        end
        if (last) begin
          busy    <= 1'b0;
          rx_byte <= rx_nxt;
          rx_full <= 1'b1;
        end
      end
    end
  end
endmodule

module ow_search_accel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       tx_valid,
  input logic [7:0] rx_byte,
  input logic       rx_full,
  input logic       slot_done,
  input logic       slot_rbit,
  input logic       acc,
  input logic [1:0] ph,
  input logic       a_r,
  input logic       dir_r
);
  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_valid));                                      // R2
  AST_RX_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rx_byte));                           // R9
  AST_FULL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rx_full);                                              // R9
  AST_DIFF_TAKES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && acc && ph == 2'd1 && slot_done && (a_r != slot_rbit)) |=> (dir_r == $past(a_r))); // R5
  AST_NOBODY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && acc && ph == 2'd1 && slot_done && a_r && slot_rbit) |=> dir_r); // R7
endmodule

bind ow_search_accel ow_search_accel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .tx_valid(tx_valid),
  .rx_byte(rx_byte), .rx_full(rx_full), .slot_done(slot_done),
  .slot_rbit(slot_rbit), .acc(acc), .ph(ph), .a_r(a_r), .dir_r(dir_r)
);

// File: tb/tb_ow_search_accel.sv
module tb_ow_search_accel;
  logic clk = 0, rst_n = 0, accel_en = 0, tx_valid = 0, rx_take = 0;
  logic slot_done = 0, slot_rbit = 0;
  logic [7:0] tx_byte = 0;
  logic busy, slot_req, slot_bit, rx_full;
  logic [7:0] rx_byte;

  int checks = 0, fails = 0, nsl = 0;
  logic [15:0] rdv = 0, wrlog = 0;

  always #5 clk = ~clk;

  ow_search_accel dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (slot_req) begin
        logic rb;
        if (nsl < 16) begin wrlog[nsl] = slot_bit; rb = rdv[nsl]; end
        else rb = 1'b1;
        repeat (2) @(negedge clk);
        slot_rbit = rb; slot_done = 1; nsl++;
        @(negedge clk);
        slot_done = 0;
      end
    end
  end

  function automatic logic [11:0] mkrv(input logic [3:0] a, input logic [3:0] b);
    logic [11:0] v = 0;
    for (int t = 0; t < 4; t++) begin v[3*t] = a[t]; v[3*t+1] = b[t]; end
    return v;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [7:0] tx, input logic [3:0] a, input logic [3:0] b);
    logic [7:0] r = 0;
    for (int t = 0; t < 4; t++) begin
      logic d, dir;
      if (a[t] != b[t]) begin d = 0; dir = a[t]; end
      else if (a[t]) begin d = 1; dir = 1; end
      else begin d = 1; dir = tx[2*t+1]; end
      r[2*t] = d; r[2*t+1] = dir;
    end
    return r;
  endfunction

  function automatic logic [3:0] wr_of(input logic [15:0] w);
    logic [3:0] r;
    for (int t = 0; t < 4; t++) r[t] = w[3*t+2];
    return r;
  endfunction

  function automatic logic [3:0] rd_of(input logic [15:0] w);
    logic [3:0] r = 0;
    for (int t = 0; t < 4; t++) r[t] = w[3*t] & w[3*t+1];
    return r;
  endfunction

  task automatic run(input logic mode, input logic [7:0] tx, input logic [15:0] rv,
                     input logic inject, output logic [7:0] rx);
    rdv = rv; nsl = 0; wrlog = 0;
    @(negedge clk);
    accel_en = mode; tx_byte = tx; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    if (inject) begin
      repeat (4) @(negedge clk);
      tx_valid = 1; tx_byte = ~tx; accel_en = ~mode;
      @(negedge clk);
      tx_valid = 0; accel_en = mode;
    end
    while (busy) @(negedge clk);
    rx = rx_byte;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 slot_req", slot_req, 0);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 rx_byte", rx_byte, 0);
  endtask

  task automatic t_normal(input logic [7:0] tx, input logic [7:0] bus);
    logic [7:0] rx;
    run(0, tx, {8'h0, bus}, 0, rx);
    chk("R3 slots", nsl, 8);
    chk("R3 written", wrlog[7:0], tx);
    chk("R3 read", rx, bus);
    chk("R9 full", rx_full, 1);
  endtask

  task automatic t_accel(input string req, input logic [7:0] tx, input logic [3:0] a, input logic [3:0] b);
    logic [7:0] rx, e;
    e = exp_byte(tx, a, b);
    run(1, tx, {4'h0, mkrv(a, b)}, 0, rx);
    chk("R4 slots", nsl, 12);
    chk("R4 read slots drive 1", rd_of(wrlog), 4'hF);
    chk({req, " dir written"}, wr_of(wrlog), {e[7], e[5], e[3], e[1]});
    chk({req, " R8 packed"}, rx, e);
  endtask

  task automatic t_ignore();
    logic [7:0] rx;
    run(1, 8'h00, 16'h0, 1, rx);
    chk("R2 slots unaffected", nsl, 12);
    chk("R2 result unaffected", rx, 8'h55);
    chk("R2 writes unaffected", wr_of(wrlog), 4'h0);
    repeat (6) @(negedge clk);
    chk("R2 no extra slot", slot_req, 0);
  endtask

  task automatic t_take();
    logic [7:0] rx;
    run(0, 8'h5A, 16'h00C3, 0, rx);
    repeat (5) @(negedge clk);
    chk("R9 full held", rx_full, 1);
    chk("R9 byte held", rx_byte, 8'hC3);
    rx_take = 1; @(negedge clk); rx_take = 0;
    chk("R9 full cleared", rx_full, 0);
  endtask

  task automatic t_search(input logic [63:0] code);
    logic [63:0] rom = 0;
    logic [7:0] rx, disc = 0;
    for (int i = 0; i < 16; i++) begin
      logic [3:0] nib = code[4*i +: 4];
      run(1, 8'h00, {4'h0, mkrv(nib, ~nib)}, 0, rx);
      for (int t = 0; t < 4; t++) begin
        rom[4*i+t] = rx[2*t+1];
        disc = disc | {7'h0, rx[2*t]};
      end
    end
    chk("R10 rom code", rom, code);
    chk("R10 no discrepancy", disc, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_normal(8'hA5, 8'h3C);
    t_normal(8'h01, 8'hFE);
    t_accel("R5/R6/R7 mixed", 8'h00, 4'b1010, 4'b1001);
    t_accel("R6 take 1", 8'hAA, 4'h0, 4'h0);
    t_accel("R6 one branch", 8'h08, 4'h0, 4'h0);
    t_accel("R5 differ", 8'hFF, 4'b0110, 4'b1001);
    t_accel("R7 nobody", 8'h00, 4'hF, 4'hF);
    t_ignore();
    t_take();
    t_search(64'hD2_0000_0A1B_2C3D_28);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule